// File: doc/BRIEF.md
# Dual-Bank Parallel I/O Port Controller

This block is a byte-wide, bus-mapped peripheral that gives a host 48 general-purpose I/O lines arranged as two identical banks. Each bank has three 8-bit ports (A, B and C) and one control register. The host reaches all eight registers through a 3-bit address, a write strobe, a read strobe and separate write and read data bytes. Each line drives an output value and an output-enable toward its pad and receives an input sample from it.

Only the basic I/O mode exists. Port A and port B change direction as whole bytes, and port C changes direction separately for its upper and lower nibble. A control write with bit 7 set reconfigures the bank's directions and clears its output latches. A control write with bit 7 clear sets or clears one port C latch bit. Inputs are resynchronised through two flops before a read can see them, and read data is registered.

Top module: `pio_dual_bank`

## Requirements
- R1: After reset every pin_oe bit is 0, every pin_out bit is 0, and both control offsets read back 0x9B, the all-input mode word.
- R2: Offsets 0, 1, 2 and 3 address bank 1 port A, port B, port C and control. Offsets 4 to 7 address the same four registers of bank 2. An access to one bank leaves the other bank unchanged.
- R3: A write to a port offset loads that port's 8-bit output latch. The latch drives pin_out for the port's lines, where pin_out bits 7:0, 15:8 and 23:16 are bank 1 A, B and C, and bits 47:24 are bank 2 in the same order. A latch holds its value when no write targets it.
- R4: A control write with bit 7 = 1 is a mode set. Bit 4 sets port A, bit 1 sets port B, bit 3 sets port C bits 7:4 and bit 0 sets port C bits 3:0, where 1 means input and 0 means output. Bits 6, 5 and 2 have no effect. The mode set clears all three output latches of that bank.
- R5: A control write with bit 7 = 0 loads bit 0 into the port C latch bit selected by bits 3:1. It leaves directions, the other latch bits and the stored mode word unchanged.
- R6: A pin_oe bit is 1 exactly when its port, or its port C nibble, is configured as an output.
- R7: A read of an input port returns its pins through a two-flop synchroniser. A pin change made before rising edge k is returned by a read strobe sampled at edge k+2 or later. A read strobe sampled at edge k still returns the old value.
- R8: A read of an output port, or of an output nibble of port C, returns the output latch. Port C combines pins and latch per nibble.
- R9: A read of a control offset returns the last mode-set word written to that bank.
- R10: bus_rdata is registered. It takes the addressed value on the rising edge where bus_rd is 1 and holds its value on every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset within the 8-byte window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 48 | Asynchronous pin samples, line n at bit n |
| pin_out | output | 48 | Output latch values, line n at bit n |
| pin_oe | output | 48 | Output enables, 1 = drive the line |

## Verification
The assertions assume that bus_wr and bus_rd are never high in the same cycle. They also assume that bus_addr and bus_wdata are settled at every rising edge where a strobe is high. The stimulus drives all bus signals at the falling edge and raises only one strobe per cycle, so these assumptions always hold. The pin inputs are allowed to change at any falling edge, because the checks on input reads account for the two-edge synchroniser delay and never sample a value before it can be visible.

// File: rtl/pio_pkg.sv
package pio_pkg;
  // control word bit positions (decoded by bank logic)
  localparam int CW_MODE = 7;
  localparam int CW_A    = 4;
  localparam int CW_CH   = 3;
  localparam int CW_B    = 1;
  localparam int CW_CL   = 0;

  // register offsets inside one bank
  typedef enum logic [1:0] {
    REG_A    = 2'd0,
    REG_B    = 2'd1,
    REG_C    = 2'd2,
    REG_CTRL = 2'd3
  } reg_sel_e;

  // direction flags, 1 = input
  typedef struct packed {
    logic a;
    logic b;
    logic ch;
    logic cl;
  } dir_t;

  localparam logic [7:0] RESET_CW = 8'h9B;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W      = 48,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pio_bank.sv
module pio_bank
  import pio_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [1:0]            addr,
  input  logic [7:0]            wdata,
  input  logic [3*PORT_W-1:0]   pin_sync,
  output logic [3*PORT_W-1:0]   pin_out,
  output logic [3*PORT_W-1:0]   pin_oe,
  output logic [PORT_W-1:0]     rd_val
);
  localparam int NIB = PORT_W / 2;
  localparam int SELW = $clog2(PORT_W);

  logic [PORT_W-1:0] lat_a, lat_b, lat_c;
  logic [7:0]        ctrl_q;
  dir_t              dir_q;

  logic wr_ctrl, mode_set, bit_op;
  assign wr_ctrl  = we && (addr == REG_CTRL);
  assign mode_set = wr_ctrl &&  wdata[CW_MODE];
  assign bit_op   = wr_ctrl && !wdata[CW_MODE];

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_a  <= '0;
      lat_b  <= '0;
      lat_c  <= '0;
      ctrl_q <= RESET_CW;
      dir_q  <= '{a: 1'b1, b: 1'b1, ch: 1'b1, cl: 1'b1};
    end else if (mode_set) begin
      lat_a    <= '0;
      lat_b    <= '0;
      lat_c    <= '0;
      ctrl_q   <= wdata;
      dir_q.a  <= wdata[CW_A];
      dir_q.b  <= wdata[CW_B];
      dir_q.ch <= wdata[CW_CH];
      dir_q.cl <= wdata[CW_CL];
    end else if (bit_op) begin
      lat_c[wdata[SELW:1]] <= wdata[0];
    end else if (we) begin
      case (addr)
        REG_A:   lat_a <= wdata;
        REG_B:   lat_b <= wdata;
        REG_C:   lat_c <= wdata;
        default: ;
      endcase
    end
  end

  logic [PORT_W-1:0] in_a, in_b, in_c, rd_c;
  assign in_a = pin_sync[PORT_W-1:0];
  assign in_b = pin_sync[2*PORT_W-1:PORT_W];
  assign in_c = pin_sync[3*PORT_W-1:2*PORT_W];
  assign rd_c = {dir_q.ch ? in_c[PORT_W-1:NIB] : lat_c[PORT_W-1:NIB],
                 dir_q.cl ? in_c[NIB-1:0]      : lat_c[NIB-1:0]};

  always_comb begin
    case (addr)
      REG_A:   rd_val = dir_q.a ? in_a : lat_a;
      REG_B:   rd_val = dir_q.b ? in_b : lat_b;
      REG_C:   rd_val = rd_c;
      default: rd_val = ctrl_q;
    endcase
  end

  assign pin_out = {lat_c, lat_b, lat_a};
  assign pin_oe  = {{NIB{~dir_q.ch}}, {NIB{~dir_q.cl}},
                    {PORT_W{~dir_q.b}}, {PORT_W{~dir_q.a}}};

  // R4: a mode set leaves every latch of the bank at zero
  p_modeset_clears_r4: assert property (@(posedge clk) disable iff (rst)
    mode_set |=> (lat_a == '0 && lat_b == '0 && lat_c == '0));

  // R5: the selected port C latch bit takes the written value
  p_bitop_loads_r5: assert property (@(posedge clk) disable iff (rst)
    bit_op |=> (lat_c[$past(wdata[SELW:1])] == $past(wdata[0])));

  // R5: directions change only through a mode set
  p_dir_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !mode_set |=> $stable(dir_q));

  // R3: port A latch holds without a write to it or a mode set
  p_lat_a_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(we && (addr == REG_A || mode_set)) |=> $stable(lat_a));
endmodule

// File: rtl/pio_dual_bank.sv
module pio_dual_bank
  import pio_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int PORT_W    = 8,
  parameter int SYNC_STG  = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [$clog2(NUM_BANKS)+1:0]    bus_addr,
  input  logic                            bus_wr,
  input  logic                            bus_rd,
  input  logic [7:0]                      bus_wdata,
  output logic [7:0]                      bus_rdata,
  input  logic [NUM_BANKS*3*PORT_W-1:0]   pin_in,
  output logic [NUM_BANKS*3*PORT_W-1:0]   pin_out,
  output logic [NUM_BANKS*3*PORT_W-1:0]   pin_oe
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int ADDR_W = BANK_W + 2;
  localparam int BLINES = 3 * PORT_W;
  localparam int LINES  = NUM_BANKS * BLINES;

  logic [LINES-1:0]  pin_sync;
  logic [PORT_W-1:0] bank_rd [NUM_BANKS];
  logic [BANK_W-1:0] bank_idx;
  logic [1:0]        sub_addr;

  assign bank_idx = bus_addr[ADDR_W-1:2];
  assign sub_addr = bus_addr[1:0];

  pio_sync #(.W(LINES), .STAGES(SYNC_STG)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic bank_we;
      assign bank_we = bus_wr && (int'(bank_idx) == b);
      pio_bank #(.PORT_W(PORT_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .we       (bank_we),
        .addr     (sub_addr),
        .wdata    (bus_wdata),
        .pin_sync (pin_sync[b*BLINES +: BLINES]),
        .pin_out  (pin_out[b*BLINES +: BLINES]),
        .pin_oe   (pin_oe[b*BLINES +: BLINES]),
        .rd_val   (bank_rd[b])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= bank_rd[bank_idx];
  end

  // R10: read data holds between read strobes
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  // R1: the first cycle after reset has no line driven
  p_reset_no_drive_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_oe == '0 && pin_out == '0));

  // R2: a write aimed at bank 1 leaves bank 2's lines alone
  p_bank_isolation_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bank_idx == '0) |=>
      ($stable(pin_out[LINES-1:BLINES]) && $stable(pin_oe[LINES-1:BLINES])));
endmodule

// File: tb/pio_dual_bank_bench.sv
module pio_dual_bank_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [47:0] pin_in = '0;
  logic [47:0] pin_out;
  logic [47:0] pin_oe;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       rd_seen = 1'b0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  pio_dual_bank u_pio_dual_bank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: pushes expected byte, then issues the read strobe
  task automatic bus_read(input logic [2:0] a, input logic [7:0] exp,
                          input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // monitor: one registered result per strobe, seen at the next falling edge
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(bus_rdata == e, t, {40'h0, bus_rdata}, {40'h0, e});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(pin_oe == '0, "R1 oe after reset", pin_oe, 48'h0);
    chk(pin_out == '0, "R1 out after reset", pin_out, 48'h0);
    bus_read(3'd3, 8'h9B, "R1 bank1 control reset word");
    bus_read(3'd7, 8'h9B, "R1 bank2 control reset word");

    // R7/R2 input reads on every port of both banks
    pin_in = 48'h665544332211;
    repeat (3) @(negedge clk);
    bus_read(3'd0, 8'h11, "R2 bank1 A input");
    bus_read(3'd1, 8'h22, "R2 bank1 B input");
    bus_read(3'd2, 8'h33, "R2 bank1 C input");
    bus_read(3'd4, 8'h44, "R2 bank2 A input");
    bus_read(3'd5, 8'h55, "R2 bank2 B input");
    bus_read(3'd6, 8'h66, "R7 bank2 C input");

    // R4/R6 bank1 all outputs, R3 latch writes
    bus_write(3'd3, 8'h80);
    chk(pin_oe == 48'h000000FFFFFF, "R6 bank1 all output", pin_oe, 48'h000000FFFFFF);
    bus_write(3'd0, 8'h5A);
    bus_write(3'd1, 8'hC3);
    bus_write(3'd2, 8'h81);
    chk(pin_out == 48'h00000081C35A, "R3 bank1 latches", pin_out, 48'h00000081C35A);
    bus_read(3'd0, 8'h5A, "R8 output port A reads latch");

    // R4/R8 bank2 split port C: upper input, lower output
    pin_in[47:40] = 8'h3C;
    bus_write(3'd7, 8'h88);
    chk(pin_oe == 48'h0FFFFFFFFFFF, "R4 bank2 nibble directions", pin_oe, 48'h0FFFFFFFFFFF);
    bus_write(3'd6, 8'hA5);
    repeat (2) @(negedge clk);
    bus_read(3'd6, 8'h35, "R8 port C nibble mix");
    bus_read(3'd4, 8'h00, "R4 mode set cleared bank2 A latch");
    bus_read(3'd7, 8'h88, "R9 bank2 control readback");
    chk(pin_out[23:0] == 24'h81C35A, "R2 bank1 latches untouched", pin_out, 48'h00000081C35A);

    // R4 ignored bits 6,5,2 and latch clear
    bus_write(3'd3, 8'hE4);
    chk(pin_out[23:0] == 24'h0, "R4 mode set clears bank1", {24'h0, pin_out[23:0]}, 48'h0);
    chk(pin_oe[23:0] == 24'hFFFFFF, "R4 ignored bits no effect", {24'h0, pin_oe[23:0]}, 48'hFFFFFF);
    bus_read(3'd3, 8'hE4, "R9 bank1 control readback");

    // R5 bit set/reset on port C
    bus_write(3'd3, 8'h0F);
    bus_write(3'd3, 8'h03);
    chk(pin_out[23:16] == 8'h82, "R5 bit set", {40'h0, pin_out[23:16]}, 48'h82);
    bus_write(3'd3, 8'h0E);
    chk(pin_out[23:16] == 8'h02, "R5 bit reset", {40'h0, pin_out[23:16]}, 48'h02);
    chk(pin_oe[23:0] == 24'hFFFFFF, "R5 directions unchanged", {24'h0, pin_oe[23:0]}, 48'hFFFFFF);
    bus_read(3'd3, 8'hE4, "R5 mode word unchanged");

    // R7 synchroniser latency, A and B inputs
    bus_write(3'd3, 8'h92);
    chk(pin_oe[23:0] == 24'hFF0000, "R6 A,B input C output", {24'h0, pin_oe[23:0]}, 48'hFF0000);
    pin_in[7:0] = 8'h77;
    bus_read(3'd0, 8'h11, "R7 read too early returns old");
    @(negedge clk);
    bus_read(3'd0, 8'h77, "R7 read after two edges");

    // R10 hold without strobe
    pin_in[7:0] = 8'h99;
    repeat (4) @(negedge clk);
    chk(bus_rdata == 8'h77, "R10 rdata holds", {40'h0, bus_rdata}, 48'h77);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule